// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Mirroring

This block collects level-sensitive interrupt requests from eight basic sources and from two wide banks of 32 sources each, masks them per source, and raises a single interrupt line while any unmasked source is active. Software reaches it through a small word-addressed register port. Through this port it reads a summary status word, reads the masked pending state of each wide bank, and sets or clears mask bits one at a time with write-1 semantics.

The summary status word is built so that one read is often enough to identify the source. It carries the basic sources, and it carries direct copies ("shortcuts") of eleven selected wide-bank sources. It also carries one flag per wide bank that is raised only by that bank's other sources. Shortcut sources are masked only in their own bank. The two per-bank flags have no mask of their own.

Top module: `tri_bank_intc`

## Requirements
- R1: After a synchronous active-low reset, every source is masked: `irq` is low and every enable or disable register reads zero, even with all sources active.
- R2: Writing to an enable register (bank 1 at 0x10, bank 2 at 0x14, basic bank at 0x18) unmasks each source whose data bit is 1. Data bits that are 0 leave their mask bit unchanged.
- R3: Writing to a disable register (bank 1 at 0x1C, bank 2 at 0x20, basic bank at 0x24) masks each source whose data bit is 1. Data bits that are 0 leave their mask bit unchanged. Reading either the enable or the disable register of a bank returns that bank's current set of unmasked sources.
- R4: The bank 1 pending register (0x04) and the bank 2 pending register (0x08) read as source AND unmask, bit for bit. This includes shortcut sources.
- R5: Bits 7..0 of the status word (0x00) read as the basic sources AND their unmask bits.
- R6: Status bit 8 is 1 exactly when an unmasked active bank 1 source is outside the shortcut list. Status bit 9 is the same for bank 2.
- R7: Status bits 10..14 copy unmasked bank 1 sources 7, 9, 10, 18, 19 in that order. Status bits 15..20 copy unmasked bank 2 sources 21, 22, 23, 24, 25, 30 in that order. These sources never raise bit 8 or bit 9.
- R8: Basic-bank enable and disable writes act only on data bits 7..0. Higher bits do not mask or unmask shortcuts or bank flags, and bits 31..8 of these registers read as zero.
- R9: Status bits 31..21 read as zero. Writes to the pending registers (0x00, 0x04, 0x08) change no mask state.
- R10: `irq` is high exactly when at least one unmasked source in any bank is active.
- R11: Sources are level-sensitive: dropping a source clears its pending and status bits with no write. Read data appears on `bus_rdata` at the clock edge that samples the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_basic | input | 8 | Basic bank level requests |
| src_bank1 | input | 32 | Bank 1 level requests |
| src_bank2 | input | 32 | Bank 2 level requests |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded properties assume that a register access lasts exactly one cycle. They also assume that enable and disable strobes never hit the same bank in one cycle, and that sources only move between clock edges. The bench drives every access as a single-cycle pulse launched on the falling edge, with sources changed only on falling edges and never during a read. Read results are predicted from a mask model that the bench keeps from its own writes, and they are compared in the cycle after the request.

// File: rtl/tbic_pkg.sv
// Package: shared constants for the three-bank interrupt controller.
// Assumes word-aligned byte addresses; wide banks fixed at 32 sources.
package tbic_pkg;
    localparam int DATA_W    = 32;
    localparam int BASIC_N   = 8;
    localparam int BANK_W    = 32;
    localparam int SC1_N     = 5;
    localparam int SC2_N     = 6;
    localparam int FLAG1_BIT = BASIC_N;
    localparam int FLAG2_BIT = BASIC_N + 1;
    localparam int SC1_BASE  = BASIC_N + 2;
    localparam int SC2_BASE  = SC1_BASE + SC1_N;
    localparam int STAT_USED = SC2_BASE + SC2_N;

    // Register offsets (byte addresses)
    localparam int OFS_STAT  = 'h00;
    localparam int OFS_PND1  = 'h04;
    localparam int OFS_PND2  = 'h08;
    localparam int OFS_SET1  = 'h10;
    localparam int OFS_SET2  = 'h14;
    localparam int OFS_SET0  = 'h18;
    localparam int OFS_CLR1  = 'h1C;
    localparam int OFS_CLR2  = 'h20;
    localparam int OFS_CLR0  = 'h24;

    // Bank 1 source mirrored at shortcut position k
    function automatic int sc1_src(input int k);
        case (k)
            0: return 7;
            1: return 9;
            2: return 10;
            3: return 18;
            default: return 19;
        endcase
    endfunction

    // Bank 2 source mirrored at shortcut position k
    function automatic int sc2_src(input int k);
        case (k)
            0: return 21;
            1: return 22;
            2: return 23;
            3: return 24;
            4: return 25;
            default: return 30;
        endcase
    endfunction

    // Bit set of bank 1 shortcut sources
    function automatic logic [BANK_W-1:0] sc1_set();
        logic [BANK_W-1:0] m;
        m = '0;
        for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
        return m;
    endfunction

    // Bit set of bank 2 shortcut sources
    function automatic logic [BANK_W-1:0] sc2_set();
        logic [BANK_W-1:0] m;
        m = '0;
        for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tbic_mask_bank.sv
// Module: one bank of per-source unmask bits with write-1-set and
// write-1-clear strobes, plus the masked pending vector.
// Assumes set_we and clr_we are never high in the same cycle.
module tbic_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wbits,
    input  logic [W-1:0] src,
    output logic [W-1:0] en,
    output logic [W-1:0] pend
);
    // Unmask register: reset masked, 1-bits of wbits set or clear
    always_ff @(posedge clk) begin
        if (!rst_n)      en <= '0;
        else if (set_we) en <= en | wbits;
        else if (clr_we) en <= en & ~wbits;
    end

    // Level pending: active source gated by its unmask bit
    assign pend = src & en;

    AST_RESET_MASKED: assert property (@(posedge clk) !rst_n |=> en == '0); // R1
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> (en & $past(wbits)) == $past(wbits)); // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (en & $past(wbits)) == '0); // R3
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> ((en ^ $past(en)) & ~$past(wbits)) == '0); // R2
endmodule

// File: rtl/tbic_status.sv
// Module: builds the summary status word from the three masked
// pending vectors and the combined interrupt request.
// Assumes the pending inputs are already masked by their banks.
module tbic_status
    import tbic_pkg::*;
#(
    parameter int STAT_W = DATA_W
) (
    input  logic [BASIC_N-1:0] pend0,
    input  logic [BANK_W-1:0]  pend1,
    input  logic [BANK_W-1:0]  pend2,
    output logic [STAT_W-1:0]  stat,
    output logic               any
);
    localparam logic [BANK_W-1:0] SC1_SET = sc1_set();
    localparam logic [BANK_W-1:0] SC2_SET = sc2_set();

    // Basic sources and per-bank flags of non-shortcut sources
    assign stat[BASIC_N-1:0] = pend0;
    assign stat[FLAG1_BIT]   = |(pend1 & ~SC1_SET);
    assign stat[FLAG2_BIT]   = |(pend2 & ~SC2_SET);

    // Shortcut mirrors for bank 1
    for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
        localparam int IDX = sc1_src(k);
        assign stat[SC1_BASE + k] = pend1[IDX];
    end

    // Shortcut mirrors for bank 2
    for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
        localparam int IDX = sc2_src(k);
        assign stat[SC2_BASE + k] = pend2[IDX];
    end

    // Unused upper status bits
    assign stat[STAT_W-1:STAT_USED] = '0;

    // Combined request over every masked source
    assign any = (|pend0) | (|pend1) | (|pend2);
endmodule

// File: rtl/tbic_regif.sv
// Module: register port decode and registered read-data mux.
// Assumes single-cycle requests; unknown addresses read zero.
module tbic_regif
    import tbic_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  stat,
    input  logic [BANK_W-1:0]  pend1,
    input  logic [BANK_W-1:0]  pend2,
    input  logic [BASIC_N-1:0] en0,
    input  logic [BANK_W-1:0]  en1,
    input  logic [BANK_W-1:0]  en2,
    output logic [2:0]         set_we,
    output logic [2:0]         clr_we,
    output logic [DATA_W-1:0]  bus_rdata
);
    logic          wr;
    logic          rd;
    int            a;
    logic [DATA_W-1:0] rd_next;

    assign wr = bus_req & bus_we;
    assign rd = bus_req & ~bus_we;
    assign a  = int'(bus_addr);

    // Write strobes per bank (index = bank number)
    always_comb begin
        set_we    = 3'b000;
        clr_we    = 3'b000;
        set_we[0] = wr && (a == OFS_SET0);
        set_we[1] = wr && (a == OFS_SET1);
        set_we[2] = wr && (a == OFS_SET2);
        clr_we[0] = wr && (a == OFS_CLR0);
        clr_we[1] = wr && (a == OFS_CLR1);
        clr_we[2] = wr && (a == OFS_CLR2);
    end

    // Read mux: enable and disable offsets both return the mask
    always_comb begin
        case (a)
            OFS_STAT:           rd_next = stat;
            OFS_PND1:           rd_next = pend1;
            OFS_PND2:           rd_next = pend2;
            OFS_SET1, OFS_CLR1: rd_next = en1;
            OFS_SET2, OFS_CLR2: rd_next = en2;
            OFS_SET0, OFS_CLR0: rd_next = {{(DATA_W-BASIC_N){1'b0}}, en0};
            default:            rd_next = '0;
        endcase
    end

    // Read data register, updated only by a read request
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_next;
    end

    AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && a == OFS_STAT) |=> bus_rdata == $past(stat)); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R11
endmodule

// File: rtl/tri_bank_intc.sv
// Module: top of the three-bank level interrupt controller.
// Connects three mask banks, the status builder and the register port.
// Assumes sources are synchronous to clk.
module tri_bank_intc
    import tbic_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BASIC_N-1:0] src_basic,
    input  logic [BANK_W-1:0]  src_bank1,
    input  logic [BANK_W-1:0]  src_bank2,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);
    logic [2:0]         set_we;
    logic [2:0]         clr_we;
    logic [BASIC_N-1:0] en0, pend0;
    logic [BANK_W-1:0]  en1, pend1, en2, pend2;
    logic [DATA_W-1:0]  stat;

    // Basic bank: only the low data bits reach its mask
    tbic_mask_bank #(.W(BASIC_N)) u_bank0 (
        .clk(clk), .rst_n(rst_n), .set_we(set_we[0]), .clr_we(clr_we[0]),
        .wbits(bus_wdata[BASIC_N-1:0]), .src(src_basic),
        .en(en0), .pend(pend0));

    // Wide bank 1
    tbic_mask_bank #(.W(BANK_W)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .set_we(set_we[1]), .clr_we(clr_we[1]),
        .wbits(bus_wdata[BANK_W-1:0]), .src(src_bank1),
        .en(en1), .pend(pend1));

    // Wide bank 2
    tbic_mask_bank #(.W(BANK_W)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .set_we(set_we[2]), .clr_we(clr_we[2]),
        .wbits(bus_wdata[BANK_W-1:0]), .src(src_bank2),
        .en(en2), .pend(pend2));

    // Summary word and combined request
    tbic_status u_status (
        .pend0(pend0), .pend1(pend1), .pend2(pend2),
        .stat(stat), .any(irq));

    // Register port
    tbic_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .stat(stat), .pend1(pend1), .pend2(pend2),
        .en0(en0), .en1(en1), .en2(en2),
        .set_we(set_we), .clr_we(clr_we), .bus_rdata(bus_rdata));

    AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat != '0)); // R10
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_we, clr_we})); // R2
    AST_FLAG1_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        stat[FLAG1_BIT] |-> (pend1 != '0)); // R6
    AST_FLAG2_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        stat[FLAG2_BIT] |-> (pend2 != '0)); // R6
endmodule

// File: tb/test_tri_bank_intc.sv
// Bench: scoreboard for tri_bank_intc. Read tasks push predicted values
// into a queue; a monitor pops and compares them as read data returns.
module test_tri_bank_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_basic = '0;
    logic [31:0] src_bank1 = '0;
    logic [31:0] src_bank2 = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]  m0 = '0;
    logic [31:0] m1 = '0;
    logic [31:0] m2 = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        chk_due = 1'b0;

    localparam int SC1[5] = '{7, 9, 10, 18, 19};
    localparam int SC2[6] = '{21, 22, 23, 24, 25, 30};

    always #4 clk = ~clk;

    tri_bank_intc i_tri_bank_intc (
        .clk(clk), .rst_n(rst_n), .src_basic(src_basic),
        .src_bank1(src_bank1), .src_bank2(src_bank2),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    // Expected status word from the requirement text (R5, R6, R7, R9)
    function automatic logic [31:0] exp_stat();
        logic [31:0] p1, p2, s;
        p1 = src_bank1 & m1;
        p2 = src_bank2 & m2;
        s = '0;
        s[7:0] = src_basic & m0;
        for (int k = 0; k < 5; k++) begin
            s[10 + k] = p1[SC1[k]];
            p1[SC1[k]] = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            s[15 + k] = p2[SC2[k]];
            p2[SC2[k]] = 1'b0;
        end
        s[8] = |p1;
        s[9] = |p2;
        return s;
    endfunction

    function automatic logic exp_irq();
        return |(src_basic & m0) | |(src_bank1 & m1) | |(src_bank2 & m2);
    endfunction

    // Monitor: a read request sampled at this edge has data ready now
    always @(posedge clk) chk_due <= bus_req && !bus_we;

    always @(negedge clk) begin
        if (chk_due) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        case (a)
            6'h10: m1 = m1 | d;
            6'h14: m2 = m2 | d;
            6'h18: m0 = m0 | d[7:0];
            6'h1C: m1 = m1 & ~d;
            6'h20: m2 = m2 & ~d;
            6'h24: m0 = m0 & ~d[7:0];
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic read_stat(input string t);
        bus_read(6'h00, exp_stat(), t);
    endtask

    task automatic set_src(input logic [7:0] b0, input logic [31:0] b1, input logic [31:0] b2);
        @(negedge clk);
        src_basic = b0; src_bank1 = b1; src_bank2 = b2;
    endtask

    task automatic check_irq(input string t);
        #1;
        checks++;
        if (irq !== exp_irq()) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", t, irq, exp_irq());
        end
    endtask

    initial begin
        // R1: reset with every source active
        src_basic = '1; src_bank1 = '1; src_bank2 = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check_irq("R1 irq after reset");
        bus_read(6'h10, 32'h0, "R1 bank1 enable after reset");
        bus_read(6'h18, 32'h0, "R1 basic enable after reset");
        bus_read(6'h20, 32'h0, "R1 bank2 disable after reset");
        bus_read(6'h00, 32'h0, "R1 status after reset");

        // R2: set bits, zero bits leave mask alone
        set_src(8'h00, 32'h0, 32'h0);
        bus_write(6'h10, 32'h0000_0001);
        bus_write(6'h10, 32'h0000_0000);
        bus_write(6'h10, 32'h0000_0080);
        bus_read(6'h10, 32'h0000_0081, "R2 bank1 enable accumulates");
        bus_read(6'h1C, 32'h0000_0081, "R3 disable offset reads mask");

        // R6, R4, R10: non-shortcut source raises bank flag
        set_src(8'h00, 32'h0000_0001, 32'h0);
        check_irq("R10 irq from bank1 source 0");
        bus_read(6'h00, 32'h0000_0100, "R6 bank1 flag");
        bus_read(6'h04, 32'h0000_0001, "R4 bank1 pending");

        // R7: shortcut source mirrors without flag
        set_src(8'h00, 32'h0000_0080, 32'h0);
        bus_read(6'h00, 32'h0000_0400, "R7 shortcut bank1 src7 no flag");
        bus_read(6'h04, 32'h0000_0080, "R4 bank1 pending shortcut");

        // R3: disable one bit, others kept
        bus_write(6'h1C, 32'h0000_0001);
        bus_read(6'h10, 32'h0000_0080, "R3 bank1 disable clears bit0");
        set_src(8'h00, 32'h0000_0081, 32'h0);
        bus_read(6'h04, 32'h0000_0080, "R3 masked source not pending");
        read_stat("R3 status after disable");

        // R8: upper bits of basic-bank writes have no effect
        bus_write(6'h18, 32'hFFFF_FF00);
        bus_read(6'h18, 32'h0, "R8 basic enable upper bits ignored");
        bus_write(6'h24, 32'hFFFF_FF00);
        bus_read(6'h00, 32'h0000_0400, "R8 shortcut not masked by basic disable");
        bus_write(6'h18, 32'h0000_0005);
        set_src(8'h07, 32'h0000_0081, 32'h0);
        bus_read(6'h00, 32'h0000_0405, "R5 basic sources in status");
        bus_read(6'h24, 32'h0000_0005, "R8 basic disable reads low mask");
        bus_write(6'h24, 32'h0000_0001);
        bus_read(6'h00, 32'h0000_0404, "R5 basic after disable");

        // R6, R7: bank 2 flag and shortcuts
        bus_write(6'h14, 32'hFFFF_FFFF);
        set_src(8'h07, 32'h0000_0081, 32'h4020_0001);
        bus_read(6'h00, 32'h0010_8604, "R7 bank2 shortcuts with flag");
        bus_read(6'h08, 32'h4020_0001, "R4 bank2 pending");
        set_src(8'h07, 32'h0000_0081, 32'h4020_0000);
        bus_read(6'h00, 32'h0010_8404, "R7 bank2 shortcuts only, no flag");

        // R7: sweep every shortcut position alone
        bus_write(6'h10, 32'hFFFF_FFFF);
        for (int k = 0; k < 5; k++) begin
            set_src(8'h00, 32'h1 << SC1[k], 32'h0);
            bus_read(6'h00, 32'h1 << (10 + k), "R7 bank1 shortcut sweep");
        end
        for (int k = 0; k < 6; k++) begin
            set_src(8'h00, 32'h0, 32'h1 << SC2[k]);
            bus_read(6'h00, 32'h1 << (15 + k), "R7 bank2 shortcut sweep");
        end

        // R9: all sources active, upper status bits zero
        set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        bus_read(6'h00, 32'h001F_FF04, "R9 full status upper bits zero");

        // R9: writes to pending registers do not touch masks
        bus_write(6'h20, 32'hFFFF_FFFF);
        bus_write(6'h08, 32'hFFFF_FFFF);
        bus_write(6'h00, 32'hFFFF_FFFF);
        bus_read(6'h14, 32'h0, "R9 pending write leaves bank2 mask");
        bus_read(6'h18, 32'h0000_0004, "R9 pending write leaves basic mask");

        // R11: level sources drop without a write
        set_src(8'h00, 32'h0, 32'h0);
        check_irq("R11 irq drops with sources");
        bus_read(6'h00, 32'h0, "R11 status clears with sources");
        bus_read(6'h04, 32'h0, "R11 bank1 pending clears");

        // R10: all masked with all active gives no irq
        bus_write(6'h1C, 32'hFFFF_FFFF);
        bus_write(6'h24, 32'hFFFF_FFFF);
        set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_irq("R10 irq low when all masked");
        bus_write(6'h14, 32'h4000_0000);
        check_irq("R10 irq from single bank2 shortcut");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule